// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This block sits between a requester and the memory system. It turns each logical address into a physical address. In user mode it adds a base register to the logical address. In the same cycle it compares the logical address against a limit register. An address beyond the limit is rejected with a protection fault and is never forwarded downstream. In kernel mode the address goes through unchanged, so privileged software can reach all of physical memory.

A small configuration port holds the two relocation registers. That port writes only while the privilege input shows kernel mode. A write attempted from user mode leaves both registers unchanged and raises a denial pulse. The selected register can always be read back on the same port. A context switch therefore works as follows: privileged software reads the outgoing pair, writes the incoming pair, then drops back to user mode.

The result is registered with one cycle of latency, and a new request may be presented on every cycle.

Top module: `reloc_unit`

## Requirements
- R1: During and after synchronous reset (`rst_n` low at a clock edge), `rsp_valid`, `fault` and `wr_denied` are 0, and both relocation registers read back as 0.
- R2: A user-mode request (`priv_kernel`=0) whose logical address is at most the limit produces, one clock later, `rsp_valid`=1, `fault`=0 and `rsp_addr` equal to base plus the logical address.
- R3: A user-mode request whose logical address is strictly greater than the limit produces, one clock later, `fault`=1 and `rsp_valid`=0. An address equal to the limit is accepted. The fault lasts exactly one cycle unless the next request also faults.
- R4: A kernel-mode request (`priv_kernel`=1) produces, one clock later, `rsp_valid`=1, `fault`=0 and `rsp_addr` equal to the logical address, whatever the base and limit hold.
- R5: A write with `cfg_we`=1 in kernel mode loads `cfg_wdata` into the register picked by `cfg_sel` (0 = base, 1 = limit). The new value is seen on `cfg_rdata` and used by requests from the next cycle on. `cfg_rdata` always shows the register picked by `cfg_sel`.
- R6: A write with `cfg_we`=1 in user mode changes neither register. One clock later it gives a one-cycle `wr_denied`=1. `wr_denied` is 0 after any other cycle.
- R7: A request is accepted on every cycle that `req_valid` is 1, with no gap. A cycle without a request gives `rsp_valid`=0 and `fault`=0 on the next cycle.
- R8: The addition is modulo 2^ADDR_W: a sum that overflows is truncated to ADDR_W bits.
- R9: `fault` and `rsp_valid` are never 1 together.
- R10: A saved base/limit pair, read out and later written back in kernel mode, restores the earlier translation exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Logical address |
| rsp_valid | output | 1 | Translated request valid downstream |
| rsp_addr | output | 32 | Physical address |
| fault | output | 1 | Protection fault pulse for a rejected request |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| wr_denied | output | 1 | Pulse: write attempted from user mode |

## Verification
Some properties are checked by the assertions on every cycle:
- fault and forwarded-valid never appear together;
- an idle cycle never produces output;
- a kernel request is passed through unchanged;
- an in-range user request is relocated, and an out-of-range one faults;
- a user write leaves both registers untouched and raises the denial pulse.

Other behaviour only shows up in the bench's scenarios:
- that written values really steer later translations;
- that the sum wraps at the top of the address space;
- that the limit boundary is inclusive;
- that a saved and restored pair gives back the earlier mapping.

// File: rtl/reloc_pkg.sv
// Package reloc_pkg
// Shared encodings for the relocation unit: register select and privilege level.
// Assumes single-bit select and privilege inputs at the top level.
package reloc_pkg;
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

    typedef enum logic {
        PRIV_USER   = 1'b0,
        PRIV_KERNEL = 1'b1
    } priv_e;
endpackage

// File: rtl/reloc_regs.sv
// Module reloc_regs
// Holds the base and limit registers and accepts writes only in kernel mode.
// A user-mode write is dropped and answered with a one-cycle denial pulse.
// Assumes synchronous active-low reset; read-back is combinational.
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              wr_denied
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic              wr_ok;
    logic              wr_bad;
    reg_sel_e          sel;

    // decode select and classify the write attempt by privilege
    always_comb begin
        sel    = reg_sel_e'(cfg_sel);
        wr_ok  = cfg_we && (priv_e'(kernel) == PRIV_KERNEL);
        wr_bad = cfg_we && (priv_e'(kernel) == PRIV_USER);
    end

    // update the base register on a permitted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_ok && sel == SEL_BASE)
            base_q <= cfg_wdata;
    end

    // update the limit register on a permitted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= '0;
        else if (wr_ok && sel == SEL_LIMIT)
            limit_q <= cfg_wdata;
    end

    // flag a write attempted from user mode for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_denied <= 1'b0;
        else
            wr_denied <= wr_bad;
    end

    // drive read-back and register outputs
    always_comb begin
        base_o    = base_q;
        limit_o   = limit_q;
        cfg_rdata = (sel == SEL_LIMIT) ? limit_q : base_q;
    end

    AST_USER_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kernel) |=> ($stable(base_q) && $stable(limit_q) && wr_denied)); // R6
    AST_DENY_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !kernel) |=> !wr_denied); // R6
endmodule

// File: rtl/reloc_check.sv
// Module reloc_check
// Combinational relocation datapath: limit compare and base add side by side.
// Neither result waits on the other; the sum is truncated to ADDR_W bits.
module reloc_check #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] laddr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] paddr,
    output logic              over_limit
);
    localparam int SUM_W = ADDR_W + 1;
    logic [SUM_W-1:0] sum_full;

    // add base and logical address, keeping the carry out of the result
    always_comb begin
        sum_full = {1'b0, base} + {1'b0, laddr};
        paddr    = sum_full[ADDR_W-1:0];
    end

    // compare the logical address to the limit in parallel with the add
    always_comb begin
        over_limit = laddr > limit;
    end
endmodule

// File: rtl/reloc_xlate.sv
// Module reloc_xlate
// Registered output stage: chooses pass-through, relocated or faulted result.
// Assumes one request per cycle at most; latency is exactly one cycle.
module reloc_xlate
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              fault
);
    logic [ADDR_W-1:0] reloc_addr;
    logic              over;
    logic              is_kernel;

    reloc_check #(.ADDR_W(ADDR_W)) u_check (
        .laddr      (req_addr),
        .base       (base),
        .limit      (limit),
        .paddr      (reloc_addr),
        .over_limit (over)
    );

    // interpret the privilege input
    always_comb begin
        is_kernel = priv_e'(kernel) == PRIV_KERNEL;
    end

    // register the chosen result for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            fault     <= 1'b0;
        end else if (!req_valid) begin
            rsp_valid <= 1'b0;
            fault     <= 1'b0;
        end else if (is_kernel) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= req_addr;
            fault     <= 1'b0;
        end else if (over) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            fault     <= 1'b1;
        end else begin
            rsp_valid <= 1'b1;
            rsp_addr  <= reloc_addr;
            fault     <= 1'b0;
        end
    end

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && rsp_valid)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !fault)); // R7
    AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kernel) |=> (rsp_valid && rsp_addr == $past(req_addr))); // R4
    AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kernel && req_addr > limit) |=> (fault && !rsp_valid)); // R3
    AST_USER_RELOC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kernel && req_addr <= limit) |=>
        (rsp_valid && rsp_addr == $past(base) + $past(req_addr))); // R2
endmodule

// File: rtl/reloc_unit.sv
// Module reloc_unit
// Top of the base/limit relocation unit: register file plus translation stage.
// Registers are read by the translation stage as they stand before any same-edge write.
module reloc_unit #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_kernel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              fault,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              wr_denied
);
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] limit_w;

    reloc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .kernel    (priv_kernel),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base_w),
        .limit_o   (limit_w),
        .cfg_rdata (cfg_rdata),
        .wr_denied (wr_denied)
    );

    reloc_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .kernel    (priv_kernel),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .base      (base_w),
        .limit     (limit_w),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .fault     (fault)
    );
endmodule

// File: tb/tb_reloc_unit.sv
module tb_reloc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_kernel = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        fault;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wr_denied;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] cur_limit = '0;

    always #2 clk = ~clk;

    reloc_unit dut (
        .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .fault(fault),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wr_denied(wr_denied)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present a request at the falling edge; check the result just after the rising edge.
    task automatic req(input bit kern, input logic [31:0] a, input string tag);
        logic [31:0] exp;
        bit          bad;
        @(negedge clk);
        priv_kernel = kern; req_valid = 1'b1; req_addr = a;
        bad = !kern && (a > cur_limit);
        exp = kern ? a : (cur_base + a);
        @(posedge clk); #1;
        if (bad) begin
            chk(fault === 1'b1 && rsp_valid === 1'b0, {tag, " fault"}, {30'd0, fault, rsp_valid}, 32'd2);
        end else begin
            chk(rsp_valid === 1'b1 && fault === 1'b0, {tag, " valid"}, {30'd0, fault, rsp_valid}, 32'd1);
            chk(rsp_addr === exp, {tag, " addr"}, rsp_addr, exp);
        end
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk(rsp_valid === 1'b0 && fault === 1'b0, tag, {30'd0, fault, rsp_valid}, 32'd0);
    endtask

    task automatic rd(input bit sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        chk(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    task automatic wr(input bit kern, input bit sel, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b0;
        priv_kernel = kern; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        if (kern) begin
            if (sel) cur_limit = d; else cur_base = d;
        end
        exp = sel ? cur_limit : cur_base;
        @(posedge clk); #1;
        chk(wr_denied === !kern, {tag, " denied"}, {31'd0, wr_denied}, {31'd0, !kern});
        chk(cfg_rdata === exp, {tag, " readback"}, cfg_rdata, exp);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk(wr_denied === !kern, {tag, " denied held to cycle end"}, {31'd0, wr_denied}, {31'd0, !kern});
        @(posedge clk); #1;
        chk(wr_denied === 1'b0, {tag, " denied one cycle"}, {31'd0, wr_denied}, 32'd0);
    endtask

    // Sweep the addresses around the limit, back to back, mixing privilege.
    task automatic sweep(input string tag);
        for (int k = -4; k <= 4; k++) begin
            longint la = longint'(cur_limit) + k;
            if (la >= 0 && la <= 64'hFFFF_FFFF) begin
                req(1'b0, la[31:0], {tag, " R2 R3 R7 R8 boundary"});
                if (k == 0) req(1'b1, la[31:0], {tag, " R4 mixed"});
            end
        end
        req(1'b0, 32'h0, {tag, " R2 zero"});
        req(1'b0, 32'hFFFF_FFFF, {tag, " R3 R8 top"});
        idle({tag, " R7 R9 idle"});
        chk(fault === 1'b0, {tag, " R3 pulse"}, {31'd0, fault}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] sv_base;
        logic [31:0] sv_limit;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid === 1'b0 && fault === 1'b0 && wr_denied === 1'b0, "R1 outputs in reset",
            {29'd0, rsp_valid, fault, wr_denied}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, 32'h0, "R1 base after reset");
        rd(1'b1, 32'h0, "R1 limit after reset");
        idle("R1 R7 quiet after reset");

        req(1'b0, 32'h0, "R3 limit zero inclusive");
        req(1'b0, 32'h1, "R3 limit zero over");
        for (int i = 0; i < 8; i++) req(1'b1, 32'h1234_0000 ^ (32'h1 << (i * 4)), "R4 passthrough");

        wr(1'b1, 1'b0, 32'h0000_1000, "R5 base");
        wr(1'b1, 1'b1, 32'h0000_00FF, "R5 limit");
        sweep("setA");

        wr(1'b1, 1'b0, 32'hFFFF_FF00, "R5 base wrap");
        wr(1'b1, 1'b1, 32'h0000_0200, "R5 limit wrap");
        sweep("setB");

        wr(1'b1, 1'b0, 32'h8000_0000, "R5 base full");
        wr(1'b1, 1'b1, 32'hFFFF_FFFF, "R5 limit full");
        sweep("setC");

        wr(1'b1, 1'b0, 32'h0004_0000, "R5 base small");
        wr(1'b1, 1'b1, 32'h0000_0010, "R5 limit small");
        for (int a = 0; a < 24; a++) req(1'b0, a[31:0], "R2 R3 R7 exhaustive small window");
        idle("R7 idle after window");

        wr(1'b0, 1'b0, 32'hDEAD_0000, "R6 user base write");
        wr(1'b0, 1'b1, 32'h0000_FFFF, "R6 user limit write");
        rd(1'b0, 32'h0004_0000, "R6 base unchanged");
        rd(1'b1, 32'h0000_0010, "R6 limit unchanged");
        req(1'b0, 32'h0000_0011, "R6 limit still enforced");
        req(1'b0, 32'h0000_0005, "R6 base still used");

        rd(1'b0, cur_base, "R10 save base");
        sv_base = cfg_rdata;
        rd(1'b1, cur_limit, "R10 save limit");
        sv_limit = cfg_rdata;
        wr(1'b1, 1'b0, 32'h0100_0000, "R10 load new base");
        wr(1'b1, 1'b1, 32'h0000_0FFF, "R10 load new limit");
        req(1'b0, 32'h0000_0800, "R10 new process mapped");
        req(1'b0, 32'h0000_0010, "R10 new process low");
        wr(1'b1, 1'b0, sv_base, "R10 restore base");
        wr(1'b1, 1'b1, sv_limit, "R10 restore limit");
        req(1'b0, 32'h0000_0010, "R10 restored edge");
        req(1'b0, 32'h0000_0011, "R10 restored fault");
        idle("R9 final idle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule